// File: doc/BRIEF.md
# Nested Trap-Level Entry Controller

This block carries out the entry half of trap handling for a processor that keeps a stack of saved contexts, one per nesting level. When a trap request arrives with a 9-bit trap type, the block acts in a single clock step. It packs the caller's condition codes, address-space identifier, processor-state bits and window pointer into one saved-state word. It stores that word, the interrupted PC and next-PC, and the trap type into the stack slot for the current level. It then forces the processor into privileged mode and applies the window-pointer change that some traps need. It also computes the handler's vector address and raises the nesting level.

The surrounding pipeline supplies the current architectural state on the `cur_*` inputs and pulses `trap_req`. One clock later, the registered `new_*` outputs hold the values the pipeline must adopt, and `trap_taken` pulses. A request made at the deepest level is refused: `trap_err` pulses, and neither the stack nor the outputs change. A read port lets the stack slots be inspected.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every `new_*` output, `trap_taken` and `trap_err` are zero, and every stack slot reads as zero on the inspection port.
- R2: When a trap is taken at level L, slot L stores a 40-bit saved-state word. Condition codes go in bits 39:32 and the address-space identifier in bits 31:24. The processor-state value ANDed with 0xF3F goes in bits 19:8. The window pointer goes in bits 2:0 (8 windows). All other bits are zero.
- R3: When a trap is taken at level L, slot L also stores the interrupted PC, the interrupted next-PC and the 9-bit trap type.
- R4: A taken trap below level MAX_TL-1 sets the processor-state output to exactly 0x015. This is FPU-enable (bit 4), privileged (bit 2) and alternate globals (bit 0).
- R5: Trap type 0x024 (clean window) produces a window pointer one lower, modulo the window count.
- R6: A trap type whose bits 8:6 equal 3'b010 (spill, `type & 0x1C0 == 0x080`) produces the window pointer minus the can-save count minus 2, modulo the window count.
- R7: A trap type whose bits 8:6 equal 3'b011 (fill, `0x0C0`) produces the window pointer plus 1, modulo the window count. Any other type leaves the pointer unchanged.
- R8: The vector output keeps bits 63:15 of the vector base. Bit 14 is set when the current level is greater than 1. The trap type occupies bits 13:5. Bits 4:0 are zero.
- R9: The new PC equals the vector address, and the new next-PC equals the vector address plus 4.
- R10: Below level MAX_TL-1 the level output is the current level plus 1. At level MAX_TL-1 the level becomes MAX_TL, and the processor-state output also carries the reduced-error bit (bit 5), giving 0x035.
- R11: A request at level MAX_TL pulses `trap_err` for one cycle. It does not pulse `trap_taken`, writes no stack slot, and leaves every `new_*` output unchanged.
- R12: `trap_taken` is a one-cycle pulse in the cycle after an accepted request. With no request, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | 9 | Trap type of the request |
| cur_pc | input | 64 | Interrupted PC |
| cur_npc | input | 64 | Interrupted next-PC |
| cur_tl | input | TL_W (3) | Current nesting level |
| cur_cwp | input | CWP_W (3) | Current window pointer |
| cur_cansave | input | CWP_W (3) | Windows available to save |
| cur_pstate | input | 12 | Current processor-state bits |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_tba | input | 64 | Current vector base |
| new_pc | output | 64 | PC to resume at (handler entry) |
| new_npc | output | 64 | Next-PC for the handler |
| new_tl | output | TL_W (3) | Level after entry |
| new_cwp | output | CWP_W (3) | Window pointer after entry |
| new_pstate | output | 12 | Processor-state bits after entry |
| new_tba | output | 64 | Vector base with the formed offset |
| trap_taken | output | 1 | Pulse: trap accepted |
| trap_err | output | 1 | Pulse: request refused at the deepest level |
| dbg_lvl | input | TL_W (3) | Stack slot to inspect |
| dbg_tstate | output | 40 | Saved-state word of that slot |
| dbg_tpc | output | 64 | Saved PC of that slot |
| dbg_tnpc | output | 64 | Saved next-PC of that slot |
| dbg_tt | output | 9 | Saved trap type of that slot |

## Verification
The hardest situation to reach is the edge of the level stack. The entry at MAX_TL-1 must set the reduced-error bit and still write the last slot. The refused request at MAX_TL must leave both that slot and the outputs unchanged. The bench drives `cur_tl` directly, so it reaches level 4 without a long chain of nested traps. It then issues the refused request with a fresh PC and trap type, and confirms through the inspection port that slot 4 still holds the previous values. The negative results of spill wrap-around are hit by choosing a can-save count larger than the window pointer.

// File: rtl/trap_entry_pkg.sv
// Package: trap_entry_pkg
// Shared widths, processor-state bit positions, trap-type classes and the
// layout of one trap stack slot. Assumes a 64-bit address space.
package trap_entry_pkg;
    localparam int ADDR_W   = 64;
    localparam int TT_W     = 9;
    localparam int CCR_W    = 8;
    localparam int ASI_W    = 8;
    localparam int PST_W    = 12;
    localparam int TSTATE_W = 40;
    localparam int VEC_LOW  = 15;

    localparam logic [PST_W-1:0] PST_SAVE_MASK = 12'hF3F;
    localparam logic [PST_W-1:0] PST_ALTG      = 12'h001;
    localparam logic [PST_W-1:0] PST_PRIV      = 12'h004;
    localparam logic [PST_W-1:0] PST_FPEN      = 12'h010;
    localparam logic [PST_W-1:0] PST_REDERR    = 12'h020;

    localparam logic [TT_W-1:0] TT_CLEAN_WIN  = 9'h024;
    localparam logic [TT_W-1:0] TT_CLASS_MASK = 9'h1C0;
    localparam logic [TT_W-1:0] TT_CLASS_SPL  = 9'h080;
    localparam logic [TT_W-1:0] TT_CLASS_FIL  = 9'h0C0;

    typedef enum logic [1:0] {
        WOP_KEEP,
        WOP_CLEAN,
        WOP_SPILL,
        WOP_FILL
    } win_op_e;

    typedef struct packed {
        logic [TSTATE_W-1:0] tstate;
        logic [ADDR_W-1:0]   tpc;
        logic [ADDR_W-1:0]   tnpc;
        logic [TT_W-1:0]     tt;
    } tslot_t;
endpackage

// File: rtl/tl_state_pack.sv
// Module: tl_state_pack
// Packs condition codes, address-space id, masked processor state and the
// window pointer into the 40-bit saved-state word. Assumes CWP_W <= 8.
module tl_state_pack
    import trap_entry_pkg::*;
#(
    parameter int CWP_W = 3
) (
    input  logic [CCR_W-1:0]    ccr,
    input  logic [ASI_W-1:0]    asi,
    input  logic [PST_W-1:0]    pstate,
    input  logic [CWP_W-1:0]    cwp,
    output logic [TSTATE_W-1:0] tstate
);
    localparam int PST_LSB = 8;
    localparam int ASI_LSB = 24;
    localparam int CCR_LSB = 32;

    // Place each field at its bit position in the saved word.
    always_comb begin
        tstate = '0;
        tstate[CCR_LSB +: CCR_W] = ccr;
        tstate[ASI_LSB +: ASI_W] = asi;
        tstate[PST_LSB +: PST_W] = pstate & PST_SAVE_MASK;
        tstate[CWP_W-1:0]        = cwp;
    end
endmodule

// File: rtl/tl_window_adj.sv
// Module: tl_window_adj
// Classifies the trap type and computes the window pointer after entry.
// Assumes the window count is a power of two, so wrap is free.
module tl_window_adj
    import trap_entry_pkg::*;
#(
    parameter int CWP_W = 3
) (
    input  logic [TT_W-1:0]  tt,
    input  logic [CWP_W-1:0] cwp,
    input  logic [CWP_W-1:0] cansave,
    output win_op_e          op,
    output logic [CWP_W-1:0] cwp_next
);
    localparam logic [CWP_W-1:0] ONE = CWP_W'(1);
    localparam logic [CWP_W-1:0] TWO = CWP_W'(2);

    // Pick the adjustment class; an exact clean-window match wins.
    always_comb begin
        if (tt == TT_CLEAN_WIN)
            op = WOP_CLEAN;
        else if ((tt & TT_CLASS_MASK) == TT_CLASS_SPL)
            op = WOP_SPILL;
        else if ((tt & TT_CLASS_MASK) == TT_CLASS_FIL)
            op = WOP_FILL;
        else
            op = WOP_KEEP;
    end

    // Apply the class adjustment modulo the window count.
    always_comb begin
        unique case (op)
            WOP_CLEAN: cwp_next = cwp - ONE;
            WOP_SPILL: cwp_next = cwp - cansave - TWO;
            WOP_FILL:  cwp_next = cwp + ONE;
            default:   cwp_next = cwp;
        endcase
    end
endmodule

// File: rtl/tl_vector_gen.sv
// Module: tl_vector_gen
// Forms the handler vector, the next level and the reduced-error flag from
// the current level, vector base and trap type.
module tl_vector_gen
    import trap_entry_pkg::*;
#(
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3
) (
    input  logic [ADDR_W-1:0] tba,
    input  logic [TT_W-1:0]   tt,
    input  logic [TL_W-1:0]   tl,
    output logic [ADDR_W-1:0] vec,
    output logic [ADDR_W-1:0] vec_npc,
    output logic [TL_W-1:0]   tl_next,
    output logic              red_set,
    output logic              at_max
);
    localparam logic [TL_W-1:0]   TL_MAX    = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0]   TL_NEAR   = TL_W'(MAX_TL - 1);
    localparam logic [TL_W-1:0]   TL_ONE    = TL_W'(1);
    localparam logic [ADDR_W-1:0] LOW_CLEAR = ~ADDR_W'({VEC_LOW{1'b1}});

    logic [VEC_LOW-1:0] low_part;

    // Build the low 15 bits: nesting flag, type, five zero bits.
    always_comb low_part = {(tl > TL_ONE), tt, 5'b0};

    // Merge the low part into the cleared base and derive next-PC.
    always_comb begin
        vec     = (tba & LOW_CLEAR) | ADDR_W'(low_part);
        vec_npc = vec + ADDR_W'(4);
    end

    // Level stepping and the reduced-error condition near the top.
    always_comb begin
        at_max  = (tl >= TL_MAX);
        red_set = (tl >= TL_NEAR);
        tl_next = at_max ? tl : tl + TL_ONE;
    end
endmodule

// File: rtl/tl_trap_stack.sv
// Module: tl_trap_stack
// Register array with one slot per level below the maximum. One write port
// indexed by level, one combinational read port; out-of-range reads give 0.
module tl_trap_stack
    import trap_entry_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_lvl,
    input  tslot_t           wr_data,
    input  logic [LVL_W-1:0] rd_lvl,
    output tslot_t           rd_data
);
    tslot_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the pushed context when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (wr_lvl == LVL_W'(g)))
                slot_q[g] <= wr_data;
        end
    end

    // Read mux for the inspection port.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_lvl == LVL_W'(i))
                rd_data = slot_q[i];
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
// Module: trap_entry_ctrl
// Top of the trap entry controller. On a request it pushes the caller context
// into the slot for the current level and registers the handler state.
// Assumes NWIN is a power of two no larger than 256.
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int MAX_TL = 5,
    localparam int CWP_W = $clog2(NWIN),
    localparam int TL_W  = $clog2(MAX_TL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_req,
    input  logic [TT_W-1:0]     trap_type,
    input  logic [ADDR_W-1:0]   cur_pc,
    input  logic [ADDR_W-1:0]   cur_npc,
    input  logic [TL_W-1:0]     cur_tl,
    input  logic [CWP_W-1:0]    cur_cwp,
    input  logic [CWP_W-1:0]    cur_cansave,
    input  logic [PST_W-1:0]    cur_pstate,
    input  logic [CCR_W-1:0]    cur_ccr,
    input  logic [ASI_W-1:0]    cur_asi,
    input  logic [ADDR_W-1:0]   cur_tba,
    output logic [ADDR_W-1:0]   new_pc,
    output logic [ADDR_W-1:0]   new_npc,
    output logic [TL_W-1:0]     new_tl,
    output logic [CWP_W-1:0]    new_cwp,
    output logic [PST_W-1:0]    new_pstate,
    output logic [ADDR_W-1:0]   new_tba,
    output logic                trap_taken,
    output logic                trap_err,
    input  logic [TL_W-1:0]     dbg_lvl,
    output logic [TSTATE_W-1:0] dbg_tstate,
    output logic [ADDR_W-1:0]   dbg_tpc,
    output logic [ADDR_W-1:0]   dbg_tnpc,
    output logic [TT_W-1:0]     dbg_tt
);
    localparam logic [PST_W-1:0] PST_ENTRY = PST_FPEN | PST_PRIV | PST_ALTG;

    logic [TSTATE_W-1:0] packed_state;
    win_op_e             win_op;
    logic [CWP_W-1:0]    cwp_calc;
    logic [ADDR_W-1:0]   vec_addr;
    logic [ADDR_W-1:0]   vec_next;
    logic [TL_W-1:0]     tl_calc;
    logic                red_calc;
    logic                lvl_full;
    logic                push_en;
    tslot_t              push_slot;
    tslot_t              peek_slot;

    tl_state_pack #(.CWP_W(CWP_W)) u_pack (
        .ccr    (cur_ccr),
        .asi    (cur_asi),
        .pstate (cur_pstate),
        .cwp    (cur_cwp),
        .tstate (packed_state)
    );

    tl_window_adj #(.CWP_W(CWP_W)) u_win (
        .tt       (trap_type),
        .cwp      (cur_cwp),
        .cansave  (cur_cansave),
        .op       (win_op),
        .cwp_next (cwp_calc)
    );

    tl_vector_gen #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_vec (
        .tba     (cur_tba),
        .tt      (trap_type),
        .tl      (cur_tl),
        .vec     (vec_addr),
        .vec_npc (vec_next),
        .tl_next (tl_calc),
        .red_set (red_calc),
        .at_max  (lvl_full)
    );

    // Assemble the slot pushed for the current level.
    always_comb begin
        push_en          = trap_req && !lvl_full;
        push_slot.tstate = packed_state;
        push_slot.tpc    = cur_pc;
        push_slot.tnpc   = cur_npc;
        push_slot.tt     = trap_type;
    end

    tl_trap_stack #(.DEPTH(MAX_TL), .LVL_W(TL_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_en),
        .wr_lvl  (cur_tl),
        .wr_data (push_slot),
        .rd_lvl  (dbg_lvl),
        .rd_data (peek_slot)
    );

    // Expose the inspected slot field by field.
    always_comb begin
        dbg_tstate = peek_slot.tstate;
        dbg_tpc    = peek_slot.tpc;
        dbg_tnpc   = peek_slot.tnpc;
        dbg_tt     = peek_slot.tt;
    end

    // Register the handler state on an accepted trap; flag refused ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc     <= '0;
            new_npc    <= '0;
            new_tl     <= '0;
            new_cwp    <= '0;
            new_pstate <= '0;
            new_tba    <= '0;
            trap_taken <= 1'b0;
            trap_err   <= 1'b0;
        end else begin
            trap_taken <= 1'b0;
            trap_err   <= 1'b0;
            if (trap_req) begin
                if (lvl_full) begin
                    trap_err <= 1'b1;
                end else begin
                    new_pc     <= vec_addr;
                    new_npc    <= vec_next;
                    new_tba    <= vec_addr;
                    new_tl     <= tl_calc;
                    new_cwp    <= (win_op == WOP_KEEP) ? cur_cwp : cwp_calc;
                    new_pstate <= red_calc ? (PST_ENTRY | PST_REDERR) : PST_ENTRY;
                    trap_taken <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tl_entry_checker.sv
// Module: tl_entry_checker
// Temporal properties of the trap entry controller, bound to its top.
module tl_entry_checker #(
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic [TL_W-1:0] cur_tl,
    input logic [63:0]     new_pc,
    input logic [63:0]     new_npc,
    input logic [TL_W-1:0] new_tl,
    input logic [11:0]     new_pstate,
    input logic            trap_taken,
    input logic            trap_err
);
    localparam logic [TL_W-1:0] TL_MAX = TL_W'(MAX_TL);

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_taken && trap_err));

    assert_level_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_tl < TL_MAX) |=> (trap_taken && new_tl == TL_W'($past(cur_tl) + 1'b1)));

    assert_refuse_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_tl == TL_MAX) |=> (trap_err && $stable(new_pc) && $stable(new_tl)));

    assert_npc_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (new_npc == new_pc + 64'd4));

    assert_privileged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (new_pstate[2] && new_pstate[4] && new_pstate[0]));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> (!trap_taken && !trap_err && $stable(new_pc) && $stable(new_pstate)));
endmodule

bind trap_entry_ctrl tl_entry_checker #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .cur_tl     (cur_tl),
    .new_pc     (new_pc),
    .new_npc    (new_npc),
    .new_tl     (new_tl),
    .new_pstate (new_pstate),
    .trap_taken (trap_taken),
    .trap_err   (trap_err)
);

// File: tb/trap_entry_ctrl_test.sv
`timescale 1ns/1ps
module trap_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [8:0]  trap_type = '0;
    logic [63:0] cur_pc = '0, cur_npc = '0, cur_tba = '0;
    logic [2:0]  cur_tl = '0, cur_cwp = '0, cur_cansave = '0;
    logic [11:0] cur_pstate = '0;
    logic [7:0]  cur_ccr = '0, cur_asi = '0;
    logic [63:0] new_pc, new_npc, new_tba;
    logic [2:0]  new_tl, new_cwp;
    logic [11:0] new_pstate;
    logic        trap_taken, trap_err;
    logic [2:0]  dbg_lvl = '0;
    logic [39:0] dbg_tstate;
    logic [63:0] dbg_tpc, dbg_tnpc;
    logic [8:0]  dbg_tt;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    trap_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_tl(cur_tl), .cur_cwp(cur_cwp),
        .cur_cansave(cur_cansave), .cur_pstate(cur_pstate), .cur_ccr(cur_ccr),
        .cur_asi(cur_asi), .cur_tba(cur_tba), .new_pc(new_pc), .new_npc(new_npc),
        .new_tl(new_tl), .new_cwp(new_cwp), .new_pstate(new_pstate),
        .new_tba(new_tba), .trap_taken(trap_taken), .trap_err(trap_err),
        .dbg_lvl(dbg_lvl), .dbg_tstate(dbg_tstate), .dbg_tpc(dbg_tpc),
        .dbg_tnpc(dbg_tnpc), .dbg_tt(dbg_tt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present a request at a falling edge; return after the capturing edge.
    task automatic fire(input logic [2:0] tl, input logic [8:0] tt, input logic [2:0] cwp,
                        input logic [2:0] cs, input logic [11:0] pst, input logic [63:0] pc);
        @(negedge clk);
        cur_tl = tl; trap_type = tt; cur_cwp = cwp; cur_cansave = cs;
        cur_pstate = pst; cur_pc = pc; cur_npc = pc + 64'd4;
        cur_ccr = 8'hA5 ^ {5'b0, tl}; cur_asi = 8'h80 | {4'b0, tt[3:0]};
        cur_tba = 64'hFFFF_0000_0001_2345;
        trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        dbg_lvl = tl;
        #1;
    endtask

    // Common checks of an accepted trap against the held inputs.
    task automatic check_taken(input string tag, input logic [2:0] exp_cwp, input logic [11:0] exp_pst);
        logic [63:0] e_vec;
        e_vec = {cur_tba[63:15], (cur_tl > 3'd1), trap_type, 5'b0};
        chk({tag, " R12 taken"}, {63'b0, trap_taken}, 64'd1);
        chk({tag, " R8 vector"}, new_tba, e_vec);
        chk({tag, " R9 pc"}, new_pc, e_vec);
        chk({tag, " R9 npc"}, new_npc, e_vec + 64'd4);
        chk({tag, " R10 level"}, {61'b0, new_tl}, {61'b0, cur_tl + 3'd1});
        chk({tag, " R4/R10 pstate"}, {52'b0, new_pstate}, {52'b0, exp_pst});
        chk({tag, " cwp R5 R6 R7"}, {61'b0, new_cwp}, {61'b0, exp_cwp});
        chk({tag, " R2 tstate"}, {24'b0, dbg_tstate},
            {24'b0, cur_ccr, cur_asi, 4'h0, cur_pstate & 12'hF3F, 5'b0, cur_cwp});
        chk({tag, " R3 tpc"}, dbg_tpc, cur_pc);
        chk({tag, " R3 tnpc"}, dbg_tnpc, cur_npc);
        chk({tag, " R3 tt"}, {55'b0, dbg_tt}, {55'b0, trap_type});
    endtask

    task automatic t_reset;
        chk("R1 pc", new_pc, 64'd0);
        chk("R1 tl", {61'b0, new_tl}, 64'd0);
        chk("R1 pstate", {52'b0, new_pstate}, 64'd0);
        chk("R1 flags", {62'b0, trap_taken, trap_err}, 64'd0);
        dbg_lvl = 3'd0; #1;
        chk("R1 slot", dbg_tpc | {24'b0, dbg_tstate}, 64'd0);
    endtask

    task automatic t_plain;
        fire(3'd0, 9'h010, 3'd3, 3'd1, 12'h0FF, 64'h0000_0000_0000_1000);
        check_taken("plain", 3'd3, 12'h015);
    endtask

    task automatic t_nested;
        fire(3'd2, 9'h041, 3'd5, 3'd0, 12'hFC0, 64'h0000_0040_0000_2000);
        check_taken("nested R8 bit14", 3'd5, 12'h015);
        chk("nested R8 bit14 set", {63'b0, new_tba[14]}, 64'd1);
    endtask

    task automatic t_clean;
        fire(3'd1, 9'h024, 3'd0, 3'd2, 12'h123, 64'h0000_0000_0000_3000);
        check_taken("clean R5 wrap", 3'd7, 12'h015);
    endtask

    task automatic t_spill;
        fire(3'd0, 9'h085, 3'd2, 3'd3, 12'h004, 64'h0000_0000_0000_4000);
        check_taken("spill R6 wrap", 3'd5, 12'h015);
    endtask

    task automatic t_fill;
        fire(3'd3, 9'h0C2, 3'd7, 3'd1, 12'h010, 64'h0000_0000_0000_5000);
        check_taken("fill R7 wrap", 3'd0, 12'h015);
    endtask

    task automatic t_near_max;
        fire(3'd4, 9'h1F7, 3'd4, 3'd4, 12'hFFF, 64'h0000_0000_0000_6000);
        check_taken("near-max R10", 3'd4, 12'h035);
    endtask

    task automatic t_at_max;
        logic [63:0] old_pc;
        old_pc = new_pc;
        fire(3'd5, 9'h011, 3'd1, 3'd0, 12'h000, 64'h0000_0000_0000_7000);
        chk("R11 err pulse", {63'b0, trap_err}, 64'd1);
        chk("R11 not taken", {63'b0, trap_taken}, 64'd0);
        chk("R11 pc held", new_pc, old_pc);
        chk("R11 tl held", {61'b0, new_tl}, 64'd5);
        dbg_lvl = 3'd4; #1;
        chk("R11 slot4 kept", dbg_tpc, 64'h0000_0000_0000_6000);
        chk("R11 slot4 tt kept", {55'b0, dbg_tt}, 64'h1F7);
        @(negedge clk);
        chk("R11 err one cycle", {63'b0, trap_err}, 64'd0);
    endtask

    task automatic t_idle;
        logic [63:0] old_pc;
        old_pc = new_pc;
        @(negedge clk);
        cur_tl = 3'd0; trap_type = 9'h0C0; cur_pc = 64'h9999;
        @(negedge clk); @(negedge clk);
        chk("R12 idle taken low", {63'b0, trap_taken}, 64'd0);
        chk("R12 idle pc hold", new_pc, old_pc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_plain();
        t_nested();
        t_clean();
        t_spill();
        t_fill();
        t_near_max();
        t_at_max();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule